// File: doc/BRIEF.md
# Pipelined Coprocessor Trace-Control Register Slave

This block is the slave end of a three-phase coprocessor access port. An access begins with an enable cycle that carries a direction bit and a 15-bit register number. Two cycles later the requester either commits or abandons the access. In that same cycle it supplies write data, or it expects read data back. The slave decodes a small set of register numbers. These map onto a bank of trace-control registers and a single 32-bit context-ID register. A one-cycle flag reports each context-ID update.

Each access takes three cycles, and the enable of one access may fall in the commit cycle of the previous one. The slave therefore keeps two accesses in flight in a two-stage pipeline. It resolves each access only when its commit cycle arrives. A two-bit security input is sampled in that commit cycle. One bit blocks bank writes made by non-secure requesters. The other bit blocks context-ID loads while trace is prohibited.

Top module: `cp_trace_regs`

## Requirements
- R1: After reset every bank register and the context-ID register read as zero, `rdata_o` is zero and `ctx_upd_o` is low.
- R2: Register-number fields: [14:12] opcode1, [11:8] CRn, [7:4] CRm, [3] coprocessor select (0 = trace-control space, 1 = system space), [2:0] opcode2. A trace-control access with select 0, opcode1 = 1 and CRn = 0 addresses bank index {CRm, opcode2}. A committed write stores `wdata_i` there. A read drives the stored value on `rdata_o` in the cycle two cycles after enable.
- R3: When `commit_i` is low in the cycle two cycles after enable, the access changes no register and produces no `ctx_upd_o` pulse.
- R4: An enable may coincide with the commit cycle of the previous access. A read issued in the commit cycle of a write to the same index returns the newly written value.
- R5: Bank indices at or above the bank depth (8) read as zero, and writes to them have no effect.
- R6: Any register number outside the accepted set is ignored on write and reads as zero. This covers opcode1 other than 1, CRn other than 0, and system-space fields other than opcode1 = 0, CRn = 13, CRm = 0, opcode2 = 1.
- R7: A committed write to system-space register number 0x0D09 while `sec_i[1]` is low loads `ctx_id_o` with `wdata_i`. In the next cycle `ctx_id_o` shows the new value and `ctx_upd_o` is high for exactly that one cycle.
- R8: When `sec_i[1]` (trace prohibited) is high in the commit cycle, a context-ID write leaves `ctx_id_o` unchanged and `ctx_upd_o` stays low.
- R9: When `sec_i[0]` (non-secure) is high in the commit cycle, a bank write is ignored. Bank reads still return the stored value.
- R10: A read of the context-ID register number returns zero.
- R11: An enable followed by a cancelled commit and any number of idle cycles leaves all register contents unchanged.
- R12: `rdata_o` is zero in every cycle that is not the commit cycle of an accepted bank read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Access start; qualifies wr_i and addr_i |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 15 | Register number |
| commit_i | input | 1 | Commit strobe, two cycles after enable |
| wdata_i | input | 32 | Write data, valid in commit cycle |
| sec_i | input | 2 | [1] trace prohibited, [0] non-secure access |
| rdata_o | output | 32 | Read data in commit cycle |
| ctx_id_o | output | 32 | Context-ID register |
| ctx_upd_o | output | 1 | One-cycle pulse after a context-ID load |

## Verification
The bench runs accesses back to back, so each read falls in the commit cycle of the write before it. A slave that updated the bank a cycle late, or read the wrong pipeline stage, would return stale data there. It cancels writes, including one followed by a long idle drain. A design that wrote at enable time, or leaked the held data later, would show a changed register. It also probes out-of-range indices, foreign opcode and CRn values, and system-space reads. In each of these, a loose decoder would store or return data. Both security bits are exercised in the commit cycle, which catches a design that ignores them or samples them at the wrong stage.

// File: rtl/cp_trace_pkg.sv
package cp_trace_pkg;
  localparam int unsigned ADDR_W = 15;

  // register-number field positions
  localparam int unsigned OP1_LSB = 12;
  localparam int unsigned CRN_LSB = 8;
  localparam int unsigned CRM_LSB = 4;
  localparam int unsigned SEL_BIT = 3;

  localparam logic [2:0] TRC_OP1 = 3'd1;
  localparam logic [3:0] TRC_CRN = 4'd0;
  localparam logic [2:0] SYS_OP1 = 3'd0;
  localparam logic [3:0] SYS_CRN = 4'd13;
  localparam logic [3:0] SYS_CRM = 4'd0;
  localparam logic [2:0] SYS_OP2 = 3'd1;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_BANK = 2'd1,
    ACC_CTX  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/cp_addr_decode.sv
module cp_addr_decode
  import cp_trace_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [2:0] op1, op2;
  logic [3:0] crn, crm;
  logic       sel;
  logic [6:0] full_idx;

  assign op1      = addr_i[OP1_LSB +: 3];
  assign crn      = addr_i[CRN_LSB +: 4];
  assign crm      = addr_i[CRM_LSB +: 4];
  assign sel      = addr_i[SEL_BIT];
  assign op2      = addr_i[2:0];
  assign full_idx = {crm, op2};
  assign idx_o    = full_idx[IDX_W-1:0];

  always_comb begin
    kind_o = ACC_NONE;
    if (!sel) begin
      if (op1 == TRC_OP1 && crn == TRC_CRN && 32'(full_idx) < DEPTH)
        kind_o = ACC_BANK;
    end else if (wr_i && op1 == SYS_OP1 && crn == SYS_CRN &&
                 crm == SYS_CRM && op2 == SYS_OP2) begin
      kind_o = ACC_CTX;
    end
  end
endmodule

// File: rtl/cp_xfer_pipe.sv
module cp_xfer_pipe
  import cp_trace_pkg::*;
#(
  parameter int unsigned LAT   = 2,
  parameter int unsigned IDX_W = 3,
  localparam int unsigned W    = IDX_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_i,
  input  acc_kind_e        kind_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             vld_o,
  output logic             wr_o,
  output acc_kind_e        kind_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [LAT-1:0]        v_q;
  logic [LAT-1:0][W-1:0] d_q;
  logic [W-1:0]          tail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      d_q <= '0;
    end else begin
      v_q    <= {v_q[LAT-2:0], en_i};
      d_q[0] <= {wr_i, kind_i, idx_i};
      for (int i = 1; i < LAT; i++) d_q[i] <= d_q[i-1];
    end
  end

  assign tail   = d_q[LAT-1];
  assign vld_o  = v_q[LAT-1];
  assign wr_o   = tail[W-1];
  assign kind_o = acc_kind_e'(tail[W-2 -: 2]);
  assign idx_o  = tail[IDX_W-1:0];

  // system-space entry only ever decoded for writes
  p_ctx_write_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && kind_o == ACC_CTX) |-> wr_o);
endmodule

// File: rtl/cp_reg_bank.sv
module cp_reg_bank #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[i] <= '0;
      else if (we_i && idx_i == IDX_W'(i))       mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/cp_trace_regs.sv
module cp_trace_regs
  import cp_trace_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LAT    = 2,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              commit_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        sec_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] ctx_id_o,
  output logic              ctx_upd_o
);
  acc_kind_e        dec_kind, s_kind;
  logic [IDX_W-1:0] dec_idx, s_idx;
  logic             s_vld, s_wr;
  logic             bank_we, ctx_we, rd_hit;
  logic [DATA_W-1:0] bank_rdata;
  logic [DATA_W-1:0] ctx_q;
  logic              upd_q;

  cp_addr_decode #(.DEPTH(DEPTH)) u_dec (
    .wr_i  (wr_i),
    .addr_i(addr_i),
    .kind_o(dec_kind),
    .idx_o (dec_idx)
  );

  cp_xfer_pipe #(.LAT(LAT), .IDX_W(IDX_W)) u_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .wr_i  (wr_i),
    .kind_i(dec_kind),
    .idx_i (dec_idx),
    .vld_o (s_vld),
    .wr_o  (s_wr),
    .kind_o(s_kind),
    .idx_o (s_idx)
  );

  // resolve in commit cycle; security sampled here too
  assign bank_we = s_vld && s_wr && s_kind == ACC_BANK && commit_i && !sec_i[0];
  assign ctx_we  = s_vld && s_wr && s_kind == ACC_CTX  && commit_i && !sec_i[1];
  assign rd_hit  = s_vld && !s_wr && s_kind == ACC_BANK;

  cp_reg_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (bank_we),
    .idx_i  (s_idx),
    .wdata_i(wdata_i),
    .rdata_o(bank_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= ctx_we;
      if (ctx_we) ctx_q <= wdata_i;
    end
  end

  assign rdata_o   = rd_hit ? bank_rdata : '0;
  assign ctx_id_o  = ctx_q;
  assign ctx_upd_o = upd_q;

  p_cancel_keeps_ctx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(ctx_id_o) && !ctx_upd_o));

  p_upd_after_commit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_upd_o |-> ($past(commit_i) && !$past(sec_i[1])));

  p_prohibit_no_upd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_i[1] |=> !ctx_upd_o);

  p_rdata_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_vld |-> rdata_o == '0);
endmodule

// File: tb/cp_trace_regs_test.sv
module cp_trace_regs_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0, wr_i = 1'b0, commit_i = 1'b0;
  logic [14:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [1:0]  sec_i = '0;
  logic [31:0] rdata_o, ctx_id_o;
  logic        ctx_upd_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  cp_trace_regs uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .wr_i(wr_i),
    .addr_i(addr_i), .commit_i(commit_i), .wdata_i(wdata_i), .sec_i(sec_i),
    .rdata_o(rdata_o), .ctx_id_o(ctx_id_o), .ctx_upd_o(ctx_upd_o)
  );

  typedef struct packed {
    logic        wr;
    logic [14:0] addr;
    logic [31:0] wd;
    logic        cm;
    logic [1:0]  sec;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  // walked back to back: each enable overlaps the previous commit cycle
  localparam vec_t VEC [NV] = '{
    '{1'b1, 15'h1000, 32'hA5A5_0001, 1'b1, 2'b00, 32'h0,          8'd2},  // R2 write idx0
    '{1'b0, 15'h1000, 32'h0,         1'b1, 2'b00, 32'hA5A5_0001,  8'd4},  // R4 overlapped read
    '{1'b1, 15'h1007, 32'h7777_0007, 1'b1, 2'b00, 32'h0,          8'd2},  // R2 idx7
    '{1'b0, 15'h1007, 32'h0,         1'b1, 2'b00, 32'h7777_0007,  8'd2},
    '{1'b1, 15'h1001, 32'hDEAD_BEEF, 1'b0, 2'b00, 32'h0,          8'd3},  // R3 cancelled
    '{1'b0, 15'h1001, 32'h0,         1'b1, 2'b00, 32'h0,          8'd3},
    '{1'b1, 15'h1010, 32'h0000_1234, 1'b1, 2'b00, 32'h0,          8'd5},  // R5 idx8
    '{1'b0, 15'h1010, 32'h0,         1'b1, 2'b00, 32'h0,          8'd5},
    '{1'b1, 15'h2000, 32'h0000_FFFF, 1'b1, 2'b00, 32'h0,          8'd6},  // R6 op1=2
    '{1'b0, 15'h1000, 32'h0,         1'b1, 2'b00, 32'hA5A5_0001,  8'd6},
    '{1'b0, 15'h2000, 32'h0,         1'b1, 2'b00, 32'h0,          8'd6},
    '{1'b1, 15'h1003, 32'h0000_3333, 1'b1, 2'b01, 32'h0,          8'd9},  // R9 non-secure write
    '{1'b0, 15'h1003, 32'h0,         1'b1, 2'b01, 32'h0,          8'd9},
    '{1'b1, 15'h1003, 32'h0000_3333, 1'b1, 2'b00, 32'h0,          8'd9},
    '{1'b0, 15'h1003, 32'h0,         1'b1, 2'b01, 32'h0000_3333,  8'd9},  // R9 read allowed
    '{1'b0, 15'h0D09, 32'h0,         1'b1, 2'b00, 32'h0,          8'd10}, // R10
    '{1'b0, 15'h1100, 32'h0,         1'b1, 2'b00, 32'h0,          8'd6}   // R6 CRn=1
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // full non-overlapped access; returns rdata seen in commit cycle
  task automatic xfer(input logic w, input logic [14:0] a, input logic [31:0] d,
                      input logic c, input logic [1:0] s, output logic [31:0] rd);
    @(negedge clk_i);
    en_i = 1'b1; wr_i = w; addr_i = a;
    @(negedge clk_i);
    en_i = 1'b0; wr_i = 1'b0; addr_i = '0;
    @(negedge clk_i);
    commit_i = c; wdata_i = d; sec_i = s;
    #1 rd = rdata_o;
    @(negedge clk_i);
    commit_i = 1'b0; wdata_i = '0; sec_i = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(rdata_o, 32'h0, "R1 rdata");
    check(ctx_id_o, 32'h0, "R1 ctx_id");
    check({31'h0, ctx_upd_o}, 32'h0, "R1 ctx_upd");

    for (int k = 0; k <= NV; k++) begin
      @(negedge clk_i);
      en_i = (k < NV);
      if (k < NV) begin wr_i = VEC[k].wr; addr_i = VEC[k].addr; end
      if (k > 0) begin
        commit_i = VEC[k-1].cm; wdata_i = VEC[k-1].wd; sec_i = VEC[k-1].sec;
      end
      #1;
      if (k > 0) check(rdata_o, VEC[k-1].exp, $sformatf("R%0d vec%0d", VEC[k-1].req, k-1));
      @(negedge clk_i);
      en_i = 1'b0; wr_i = 1'b0; addr_i = '0;
      commit_i = 1'b0; wdata_i = '0; sec_i = '0;
      #1 check(rdata_o, 32'h0, "R12 idle cycle");
    end

    // R7 context load and single-cycle pulse
    xfer(1'b1, 15'h0D09, 32'hC0FF_EE01, 1'b1, 2'b00, rd);
    check(ctx_id_o, 32'hC0FF_EE01, "R7 ctx load");
    check({31'h0, ctx_upd_o}, 32'h1, "R7 pulse high");
    @(negedge clk_i);
    check({31'h0, ctx_upd_o}, 32'h0, "R7 pulse width");

    // R8 trace prohibited
    xfer(1'b1, 15'h0D09, 32'h1111_2222, 1'b1, 2'b10, rd);
    check(ctx_id_o, 32'hC0FF_EE01, "R8 ctx held");
    check({31'h0, ctx_upd_o}, 32'h0, "R8 no pulse");

    // R3 cancelled context write
    xfer(1'b1, 15'h0D09, 32'h3333_4444, 1'b0, 2'b00, rd);
    check(ctx_id_o, 32'hC0FF_EE01, "R3 ctx held");
    check({31'h0, ctx_upd_o}, 32'h0, "R3 no pulse");

    // R6 system space with wrong opcode2
    xfer(1'b1, 15'h0D0A, 32'h5555_6666, 1'b1, 2'b00, rd);
    check(ctx_id_o, 32'hC0FF_EE01, "R6 sys op2 ignored");

    // R11 cancelled write then long drain
    xfer(1'b1, 15'h1002, 32'h0000_0022, 1'b1, 2'b00, rd);
    @(negedge clk_i);
    en_i = 1'b1; wr_i = 1'b1; addr_i = 15'h1002;
    @(negedge clk_i);
    en_i = 1'b0; wr_i = 1'b0; addr_i = '0;
    @(negedge clk_i);
    wdata_i = 32'h0000_0099;  // commit stays low
    @(negedge clk_i);
    wdata_i = '0;
    repeat (6) @(negedge clk_i);
    xfer(1'b0, 15'h1002, 32'h0, 1'b1, 2'b00, rd);
    check(rd, 32'h0000_0022, "R11 drain keeps value");

    // R1 reset clears bank and context
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    check(ctx_id_o, 32'h0, "R1 ctx after reset");
    xfer(1'b0, 15'h1000, 32'h0, 1'b1, 2'b00, rd);
    check(rd, 32'h0, "R1 bank after reset");

    finish_run();
  end
endmodule